// File: doc/BRIEF.md
# Decrement Instruction Form Decoder

This block looks at one instruction that an earlier stage has already split into its parts. The parts are the prefix flags, an optional REX byte, the primary opcode byte and the ModRM byte. The block decides whether the instruction is an integer decrement. When it is, the block reports the operand width, whether the target is a register or memory, and which register is the target. It also reports whether that register is a legacy high-byte register.

A locked decrement of a register destination is rejected with an invalid-opcode flag. The same single-byte opcodes 48h–4Fh mean different things in the two modes. In legacy/compatibility mode they are short register decrements. In 64-bit mode they are REX prefixes, and this block must never treat them as a decrement.

The outputs are registered. They appear one clock after the inputs are sampled, and they are all zero whenever the sampled instruction is not a decrement.

Top module: `dec_form_decoder`

## Requirements
- R1: Opcode FEh with ModRM bits [5:3] equal to 1 gives `dec_valid`=1 with `op_size`=0 (8 bits). The `op_size` encoding is 0=8, 1=16, 2=32 and 3=64 bits.
- R2: Opcode FFh with ModRM bits [5:3] equal to 1 gives a decrement whose width depends on the mode:
  - In 64-bit mode with REX present and REX.W set, the width is 64 bits (`op_size`=3), whatever the state of `opsz_pfx`.
  - Otherwise `opsz_pfx` gives 16 bits (`op_size`=1).
  - Otherwise the width is 32 bits (`op_size`=2).
  - In legacy mode the REX inputs never produce 64 bits.
- R3: In legacy mode, opcodes 48h–4Fh give a register decrement. `reg_idx` equals opcode bits [2:0], `is_mem`=0, and the width is 16 bits with `opsz_pfx`, else 32 bits.
- R4: In 64-bit mode, opcodes 48h–4Fh give `dec_valid`=0 and `ud_fault`=0.
- R5: For FEh/FFh, the ModRM mod field (bits [7:6]) selects the destination:
  - When mod=3, the destination is a register with `is_mem`=0 and `reg_idx`={REX.B, ModRM[2:0]}. REX.B counts only when `mode64`=1 and `rex_present`=1.
  - Any other mod value gives `is_mem`=1 and `reg_idx`=0.
- R6: For a byte register decrement with no effective REX (the REX byte counts only in 64-bit mode), ModRM[2:0] values 4–7 give `hi_byte`=1 and `reg_idx`=ModRM[2:0]−4. With REX effective, the same values give `hi_byte`=0 and `reg_idx`=4–7. In every other case `hi_byte`=0.
- R7: A decrement with `lock_pfx`=1 and a register destination gives `ud_fault`=1 with all other outputs 0. A locked decrement of a memory destination decodes normally with `ud_fault`=0.
- R8: Opcode FEh/FFh with ModRM[5:3]≠1, any other non-decrement opcode, or `in_valid`=0 gives all outputs 0.
- R9: Outputs are registered with one cycle of latency, and they are 0 during reset and right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction descriptor is present |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility mode |
| lock_pfx | input | 1 | LOCK prefix was seen |
| opsz_pfx | input | 1 | Operand-size (66h) prefix was seen |
| rex_present | input | 1 | A REX byte was seen |
| rex_w | input | 1 | REX.W bit |
| rex_b | input | 1 | REX.B bit |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | ModRM byte (ignored for 48h–4Fh) |
| dec_valid | output | 1 | A valid decrement was decoded |
| op_size | output | 2 | Width: 0=8, 1=16, 2=32, 3=64 bits |
| is_mem | output | 1 | Destination is memory |
| reg_idx | output | 4 | Register number of the destination |
| hi_byte | output | 1 | Destination is a legacy high-byte register |
| ud_fault | output | 1 | Invalid-opcode exception |

## Verification
A sweep covers all 256 opcode values in both modes, each with several ModRM and prefix patterns. This separates the short forms 48h–4Fh, the FEh/FFh group forms and all other opcodes, and it shows the short forms being suppressed in 64-bit mode.

Directed patterns then toggle REX presence alone on byte registers 4–7, which separates high-byte selection from the uniform low-byte registers. They also flip REX.W against 66h to show which prefix wins, and apply LOCK to register and to memory destinations. Legacy-mode vectors that carry REX bits show that those bits are ignored there.

// File: rtl/dec_form_decoder.sv
module dec_form_decoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       mode64,
  input  logic       lock_pfx,
  input  logic       opsz_pfx,
  input  logic       rex_present,
  input  logic       rex_w,
  input  logic       rex_b,
  input  logic [7:0] opcode,
  input  logic [7:0] modrm,
  output logic       dec_valid,
  output logic [1:0] op_size,
  output logic       is_mem,
  output logic [3:0] reg_idx,
  output logic       hi_byte,
  output logic       ud_fault
);

  localparam logic [1:0] SZ8  = 2'd0;
  localparam logic [1:0] SZ16 = 2'd1;
  localparam logic [1:0] SZ32 = 2'd2;
  localparam logic [1:0] SZ64 = 2'd3;
  localparam logic [2:0] EXT_DEC = 3'd1;

  logic rex_on, grp_hit, short_hit, reg_dst, hit, fault, byte_op, hi_sel, ok;
  logic [1:0] size_n;
  logic [3:0] idx_n;

  assign rex_on    = mode64 & rex_present;
  assign grp_hit   = (opcode[7:1] == 7'h7F) && (modrm[5:3] == EXT_DEC);
  assign short_hit = !mode64 && (opcode[7:3] == 5'b01001);
  assign reg_dst   = short_hit | (modrm[7:6] == 2'b11);
  assign hit       = in_valid & (grp_hit | short_hit);
  assign fault     = hit & lock_pfx & reg_dst;
  assign ok        = hit & ~fault;
  assign byte_op   = grp_hit & ~opcode[0];
  assign hi_sel    = byte_op & reg_dst & ~rex_on & modrm[2];

  always_comb begin
    if (byte_op)                      size_n = SZ8;
    else if (grp_hit & rex_on & rex_w) size_n = SZ64;
    else if (opsz_pfx)                size_n = SZ16;
    else                              size_n = SZ32;
  end

  always_comb begin
    if (short_hit)    idx_n = {1'b0, opcode[2:0]};
    else if (!reg_dst) idx_n = 4'd0;
    else if (hi_sel)  idx_n = {2'b00, modrm[1:0]};
    else              idx_n = {rex_on & rex_b, modrm[2:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      op_size   <= SZ8;
      is_mem    <= 1'b0;
      reg_idx   <= 4'd0;
      hi_byte   <= 1'b0;
      ud_fault  <= 1'b0;
    end else begin
      dec_valid <= ok;
      op_size   <= ok ? size_n : SZ8;
      is_mem    <= ok & ~reg_dst;
      reg_idx   <= ok ? idx_n : 4'd0;
      hi_byte   <= ok & hi_sel;
      ud_fault  <= fault;
    end
  end

endmodule

module dec_form_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       mode64,
  input logic       lock_pfx,
  input logic [7:0] opcode,
  input logic       dec_valid,
  input logic [1:0] op_size,
  input logic       is_mem,
  input logic [3:0] reg_idx,
  input logic       hi_byte,
  input logic       ud_fault
);

  a_r7_fault_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> !dec_valid);

  a_r7_fault_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    ud_fault |-> $past(lock_pfx));

  a_r4_rex_bytes_silent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && mode64 && opcode[7:3] == 5'b01001) |-> (!dec_valid && !ud_fault));

  a_r6_hi_byte_shape: assert property (@(posedge clk) disable iff (!rst_n)
    hi_byte |-> (dec_valid && op_size == 2'd0 && !is_mem && reg_idx < 4'd4));

  a_r5_mem_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_mem |-> (reg_idx == 4'd0 && dec_valid));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> (!dec_valid && !ud_fault));

  a_r2_wide_only_64: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && op_size == 2'd3) |-> $past(mode64));

endmodule

bind dec_form_decoder dec_form_decoder_chk u_chk (.*);

// File: tb/dec_form_decoder_bench.sv
module dec_form_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, mode64 = 0, lock_pfx = 0, opsz_pfx = 0;
  logic rex_present = 0, rex_w = 0, rex_b = 0;
  logic [7:0] opcode = 0, modrm = 0;
  logic dec_valid, is_mem, hi_byte, ud_fault;
  logic [1:0] op_size;
  logic [3:0] reg_idx;

  int compared = 0;
  int mismatched = 0;
  logic [9:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_form_decoder u_dec_form_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode64(mode64),
    .lock_pfx(lock_pfx), .opsz_pfx(opsz_pfx), .rex_present(rex_present),
    .rex_w(rex_w), .rex_b(rex_b), .opcode(opcode), .modrm(modrm),
    .dec_valid(dec_valid), .op_size(op_size), .is_mem(is_mem),
    .reg_idx(reg_idx), .hi_byte(hi_byte), .ud_fault(ud_fault));

  function automatic logic [9:0] model(input bit v, input bit m64, input bit lk,
      input bit o66, input bit rp, input bit rw, input bit rb,
      input logic [7:0] op, input logic [7:0] mr);
    int bits = 0;
    int r = 0;
    bit mem = 0, hi = 0, isdec = 0;
    logic [1:0] code;
    bit rex_eff = m64 && rp;
    if (!v) return 10'd0;
    if ((op == 8'hFE || op == 8'hFF) && mr[5:3] == 3'd1) begin
      isdec = 1;
      if (op == 8'hFE) bits = 8;
      else if (rex_eff && rw) bits = 64;
      else bits = o66 ? 16 : 32;
      mem = (mr[7:6] != 2'd3);
      if (!mem) begin
        r = int'(mr[2:0]) + ((rex_eff && rb) ? 8 : 0);
        if (bits == 8 && !rex_eff && r >= 4) begin
          hi = 1;
          r = r - 4;
        end
      end
    end else if (!m64 && op >= 8'h48 && op <= 8'h4F) begin
      isdec = 1;
      bits = o66 ? 16 : 32;
      r = int'(op) - 'h48;
    end
    if (!isdec) return 10'd0;
    if (lk && !mem) return 10'd1;
    case (bits)
      8: code = 2'd0;
      16: code = 2'd1;
      32: code = 2'd2;
      default: code = 2'd3;
    endcase
    return {1'b1, code, mem, 4'(r), hi, 1'b0};
  endfunction

  function automatic string auto_tag(input bit m64, input logic [7:0] op, input logic [7:0] mr);
    if (op == 8'hFE && mr[5:3] == 3'd1) return "R1";
    if (op == 8'hFF && mr[5:3] == 3'd1) return "R2";
    if (op[7:3] == 5'b01001) return m64 ? "R4" : "R3";
    return "R8";
  endfunction

  function automatic logic [9:0] observed();
    return {dec_valid, op_size, is_mem, reg_idx, hi_byte, ud_fault};
  endfunction

  task automatic compare_out(input logic [9:0] exp, input string tag);
    compared++;
    if (observed() !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b", tag, observed(), exp);
    end
  endtask

  task automatic send(input string tag, input bit v, input bit m64, input bit lk,
      input bit o66, input bit rp, input bit rw, input bit rb,
      input logic [7:0] op, input logic [7:0] mr);
    @(negedge clk);
    if (exp_q.size() > 0) compare_out(exp_q.pop_front(), tag_q.pop_front());
    in_valid = v; mode64 = m64; lock_pfx = lk; opsz_pfx = o66;
    rex_present = rp; rex_w = rw; rex_b = rb; opcode = op; modrm = mr;
    exp_q.push_back(model(v, m64, lk, o66, rp, rw, rb, op, mr));
    tag_q.push_back(tag);
  endtask

  initial begin
    int limit = 150000;
    repeat (limit) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare_out(10'd0, "R9");
    rst_n = 1'b1;
    // R1 byte register and memory
    send("R1", 1, 0, 0, 0, 0, 0, 0, 8'hFE, 8'hC9);
    send("R1", 1, 1, 0, 0, 0, 0, 0, 8'hFE, 8'h0E);
    // R2 widths
    send("R2", 1, 0, 0, 0, 0, 0, 0, 8'hFF, 8'hCB);
    send("R2", 1, 0, 0, 1, 0, 0, 0, 8'hFF, 8'hCB);
    send("R2", 1, 1, 0, 1, 1, 1, 0, 8'hFF, 8'hCB);
    send("R2", 1, 1, 0, 1, 1, 0, 0, 8'hFF, 8'hCB);
    send("R2", 1, 0, 0, 0, 1, 1, 1, 8'hFF, 8'hCB);
    // R3 short forms in legacy mode
    send("R3", 1, 0, 0, 0, 0, 0, 0, 8'h48, 8'h00);
    send("R3", 1, 0, 0, 1, 0, 0, 0, 8'h4F, 8'hFF);
    // R4 same bytes in 64-bit mode
    send("R4", 1, 1, 0, 0, 0, 0, 0, 8'h4B, 8'hC8);
    send("R4", 1, 1, 1, 1, 0, 0, 0, 8'h48, 8'hC8);
    // R5 REX.B extension, legacy REX ignored, memory forms
    send("R5", 1, 1, 0, 0, 1, 0, 1, 8'hFF, 8'hCA);
    send("R5", 1, 0, 0, 0, 1, 0, 1, 8'hFF, 8'hCA);
    send("R5", 1, 1, 0, 0, 1, 0, 1, 8'hFF, 8'h8D);
    send("R5", 1, 1, 0, 0, 0, 0, 0, 8'hFF, 8'h4F);
    // R6 high-byte vs REX low-byte registers
    for (int rm = 4; rm < 8; rm++) begin
      send("R6", 1, 1, 0, 0, 0, 0, 0, 8'hFE, 8'hC8 | 8'(rm));
      send("R6", 1, 1, 0, 0, 1, 0, 0, 8'hFE, 8'hC8 | 8'(rm));
      send("R6", 1, 0, 0, 0, 1, 0, 0, 8'hFE, 8'hC8 | 8'(rm));
    end
    send("R6", 1, 1, 0, 0, 1, 0, 1, 8'hFE, 8'hCC);
    // R7 lock
    send("R7", 1, 1, 1, 0, 0, 0, 0, 8'hFF, 8'hC9);
    send("R7", 1, 0, 1, 0, 0, 0, 0, 8'h4A, 8'h00);
    send("R7", 1, 1, 1, 0, 0, 0, 0, 8'hFE, 8'h08);
    // R8 non-decrement forms and idle
    send("R8", 1, 1, 0, 0, 0, 0, 0, 8'hFF, 8'hC1);
    send("R8", 1, 1, 0, 0, 0, 0, 0, 8'hFE, 8'hC0);
    send("R8", 0, 0, 0, 0, 0, 0, 0, 8'hFF, 8'hC9);
    send("R8", 1, 0, 1, 0, 0, 0, 0, 8'h40, 8'h00);
    // sweep all opcodes in both modes
    for (int m = 0; m < 2; m++) begin
      for (int op = 0; op < 256; op++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0] mr;
          mr = 8'($urandom);
          if (k < 4) mr[5:3] = 3'd1;
          if (k[0]) mr[7:6] = 2'd3;
          send(auto_tag(m[0], 8'(op), mr), 1, m[0], k == 5, k[1], k[2], k[1], k[0],
               8'(op), mr);
        end
      end
    end
    send("R9", 0, 0, 0, 0, 0, 0, 0, 8'h00, 8'h00);
    @(negedge clk);
    compare_out(exp_q.pop_front(), tag_q.pop_front());
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule